// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a byte-wide SPI master driven from a small synchronous register port. The host sets clock polarity, clock phase, bit order and slave-select handling in a control register, and chooses the serial clock rate with a 3-bit divider code. It then writes a byte to the data register. That write starts an 8-bit full-duplex exchange: 16 SCLK edges that shift the byte out on MOSI and a byte in from MISO. When the exchange is complete, a completion flag is set. An interrupt line follows that flag when interrupts are enabled. The received byte is then read from the same data register address.

The host port has no back-pressure. A data write that arrives while an exchange is running is dropped, so the host polls the busy bit or waits for the completion flag before writing the next byte. Reads are combinational from the address. Only the status-then-data access sequence has a side effect: it clears the flag.

Top module: `spi_master_core`

## Requirements
- R1: After reset every register reads zero. SCLK is low, `ss_n` is high and `irq` is low. The register addresses are: 0 = control, 1 = rate, 2 = status, 3 = data. Control bits: 0 enable, 1 clock polarity, 2 clock phase, 3 LSB-first, 4 automatic select, 5 interrupt enable, 6 manual select level. Status bits: bit 7 completion flag, bit 0 busy.
- R2: A data-register write while enabled and idle starts an exchange on the next clock. The exchange has exactly 16 SCLK edges. With rate code N, edge k comes 2^N·k system clocks after the start edge. The busy bit stays set for 17·2^N clocks.
- R3: When no exchange is running, SCLK rests at the clock-polarity bit: low for 0, high for 1.
- R4: With phase 0, each bit is on MOSI before the odd (leading) edges, and MISO is sampled on those edges. With phase 1, a new bit is driven on each odd edge and MISO is sampled on the even edges.
- R5: With the LSB-first bit clear, bit 7 goes out and comes in first. With it set, bit 0 goes first. The received byte is always read back in normal bit significance.
- R6: With automatic select, `ss_n` is low from the cycle after the start write until the exchange ends, which is 2^N clocks after the 16th edge. Without automatic select, `ss_n` is the inverse of the manual select level bit and is held across bytes.
- R7: When an exchange ends, the completion flag sets and the busy bit clears in the same clock. A data-register read then returns the received byte.
- R8: `irq` is high exactly when the completion flag and the interrupt-enable bit are both set.
- R9: The flag clears only when a status read that sees it set is followed by a data-register access (read or write). A data access without that prior status read leaves the flag set.
- R10: A data write during an exchange is ignored. The transmitted byte and the edge timing are unchanged.
- R11: A data write while the enable bit is clear starts nothing. Clearing enable during an exchange aborts it: SCLK returns to rest, `ss_n` releases and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effects only) |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from the address |
| irq | output | 1 | Completion interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The assertions rely on these conditions at the inputs:
- The host never asserts `host_wr` and `host_rd` in the same cycle.
- The rate and the polarity, phase and order bits change only while no exchange is running.
- `miso` changes only away from the sampling edges.

The bench keeps to these conditions. It writes configuration only after its reference model shows the block idle. Its slave model changes MISO on the falling system-clock edge after a launch edge. Aborts are issued only well before the final edge.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

  localparam int HOST_AW = 2;

  localparam logic [HOST_AW-1:0] REG_CTRL = 2'd0;
  localparam logic [HOST_AW-1:0] REG_RATE = 2'd1;
  localparam logic [HOST_AW-1:0] REG_STAT = 2'd2;
  localparam logic [HOST_AW-1:0] REG_DATA = 2'd3;

  // packed from bit 6 down to bit 0
  typedef struct packed {
    logic ss_force;
    logic irq_en;
    logic auto_ss;
    logic lsb_first;
    logic cpha;
    logic cpol;
    logic enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    XF_IDLE   = 2'd0,
    XF_ACTIVE = 2'd1,
    XF_TRAIL  = 2'd2
  } xfer_state_t;

endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  localparam int CNT_W = (1 << RATE_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  // limit = 2^rate - 1, built as a thermometer of ones
  always_comb begin
    for (int i = 0; i < CNT_W; i++) begin
      limit[i] = (int'(rate) > i);
    end
  end

  assign tick = run && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_tick_only_running_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              start,
  input  logic              cpha,
  input  logic              lsb_first,
  input  logic              tick,
  input  logic              miso,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              run,
  output logic              done,
  output logic              sclk_ph,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);

  localparam int LAST_EDGE = 2 * DATA_W;
  localparam int EDGE_W    = $clog2(LAST_EDGE + 1);

  xfer_state_t       state;
  logic [EDGE_W-1:0] edge_cnt;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] tx_rev;
  logic [DATA_W-1:0] rx_rev;
  logic              next_odd;
  logic              do_sample;
  logic              do_launch;
  logic              at_last;

  for (genvar g = 0; g < DATA_W; g++) begin : g_rev
    assign tx_rev[g] = tx_byte[DATA_W-1-g];
    assign rx_rev[g] = rx_sh[DATA_W-1-g];
  end

  // the edge about to happen is odd (leading) when the count is even
  assign next_odd  = ~edge_cnt[0];
  assign do_sample = cpha ? ~next_odd : next_odd;
  assign do_launch = cpha ? (next_odd && (edge_cnt != '0)) : ~next_odd;
  assign at_last   = (edge_cnt == EDGE_W'(LAST_EDGE - 1));

  assign run     = (state != XF_IDLE);
  assign done    = (state == XF_TRAIL) && tick && enable;
  assign mosi    = tx_sh[DATA_W-1];
  assign rx_byte = lsb_first ? rx_rev : rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= XF_IDLE;
      edge_cnt <= '0;
      sclk_ph  <= 1'b0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else if (!enable) begin
      state    <= XF_IDLE;
      edge_cnt <= '0;
      sclk_ph  <= 1'b0;
    end else begin
      unique case (state)
        XF_IDLE: begin
          if (start) begin
            state    <= XF_ACTIVE;
            edge_cnt <= '0;
            sclk_ph  <= 1'b0;
            tx_sh    <= lsb_first ? tx_rev : tx_byte;
          end
        end
        XF_ACTIVE: begin
          if (tick) begin
            sclk_ph  <= ~sclk_ph;
            edge_cnt <= edge_cnt + 1'b1;
            if (do_sample) rx_sh <= {rx_sh[DATA_W-2:0], miso};
            if (do_launch) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            if (at_last) state <= XF_TRAIL;
          end
        end
        XF_TRAIL: begin
          if (tick) state <= XF_IDLE;
        end
        default: state <= XF_IDLE;
      endcase
    end
  end

  assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (state == XF_IDLE));

  assert_edge_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$stable(sclk_ph)) |-> $past(tick));

  assert_frame_edges_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run) && $past(enable)) |-> ($past(edge_cnt) == EDGE_W'(LAST_EDGE)));

  assert_idle_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == XF_IDLE) |-> (sclk_ph == 1'b0));

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [HOST_AW-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               busy,
  input  logic               done,
  input  logic [DATA_W-1:0]  rx_byte,
  output logic [DATA_W-1:0]  rdata,
  output ctrl_t              cfg,
  output logic [RATE_W-1:0]  rate,
  output logic               start,
  output logic               flag,
  output logic               irq
);

  logic [DATA_W-1:0] rx_hold;
  logic              armed;
  logic              data_acc;
  logic              stat_rd;

  assign data_acc = (wr_en || rd_en) && (addr == REG_DATA);
  assign stat_rd  = rd_en && (addr == REG_STAT);
  assign start    = wr_en && (addr == REG_DATA) && cfg.enable && !busy;
  assign irq      = flag && cfg.irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg  <= '0;
      rate <= '0;
    end else if (wr_en) begin
      if (addr == REG_CTRL) cfg  <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (addr == REG_RATE) rate <= wdata[RATE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_hold <= '0;
    end else if (done) begin
      rx_hold <= rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (done) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else if (data_acc) begin
      armed <= 1'b0;
      if (armed) flag <= 1'b0;
    end else if (stat_rd && flag) begin
      armed <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      REG_CTRL: rdata = DATA_W'({1'b0, cfg});
      REG_RATE: rdata = DATA_W'(rate);
      REG_STAT: begin
        rdata[DATA_W-1] = flag;
        rdata[0]        = busy;
      end
      REG_DATA: rdata = rx_hold;
      default:  rdata = '0;
    endcase
  end

  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !armed && !done) |=> flag);

  assert_done_needs_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
  import spi_master_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               irq,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso,
  output logic               ss_n
);

  ctrl_t             cfg;
  logic [RATE_W-1:0] rate;
  logic              start;
  logic              flag;
  logic              run;
  logic              done;
  logic              tick;
  logic              sclk_ph;
  logic [DATA_W-1:0] rx_byte;

  spi_host_regs #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (host_wr),
    .rd_en  (host_rd),
    .addr   (host_addr),
    .wdata  (host_wdata),
    .busy   (run),
    .done   (done),
    .rx_byte(rx_byte),
    .rdata  (host_rdata),
    .cfg    (cfg),
    .rate   (rate),
    .start  (start),
    .flag   (flag),
    .irq    (irq)
  );

  spi_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .rate (rate),
    .tick (tick)
  );

  spi_shift_engine #(.DATA_W(DATA_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (cfg.enable),
    .start    (start),
    .cpha     (cfg.cpha),
    .lsb_first(cfg.lsb_first),
    .tick     (tick),
    .miso     (miso),
    .tx_byte  (host_wdata),
    .run      (run),
    .done     (done),
    .sclk_ph  (sclk_ph),
    .mosi     (mosi),
    .rx_byte  (rx_byte)
  );

  assign sclk = cfg.cpol ^ sclk_ph;
  assign ss_n = cfg.auto_ss ? ~run : ~cfg.ss_force;

  assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run) && $past(cfg.enable)) |-> flag);

  assert_abort_no_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(run) && !$past(cfg.enable) && !$past(flag)) |-> !flag);

endmodule

// File: tb/test_spi_master_core.sv
`timescale 1ns/1ps
module test_spi_master_core;
  import spi_master_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       irq, sclk, mosi, ss_n;
  logic       miso = 1'b0;

  spi_master_core i_spi_master_core (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  bit mon_on = 0;
  bit r_en, r_cpol, r_cpha, r_lsb, r_auto, r_ie, r_force;
  int r_rate = 0;
  bit r_active = 0;
  int r_j = 0;
  bit r_flag = 0, r_armed = 0;
  int r_abort = 0;

  // slave model state
  logic [7:0] s_tx = '0, s_rx = '0;
  int   s_cnt = 16;
  logic s_prev = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_access(input logic [1:0] a, input logic [7:0] d, input bit is_wr);
    if (is_wr && a == REG_CTRL) begin
      {r_force, r_ie, r_auto, r_lsb, r_cpha, r_cpol, r_en} = d[6:0];
      if (!r_en && r_active) r_abort = 1;
    end
    if (is_wr && a == REG_RATE) r_rate = int'(d[2:0]);
    if (!is_wr && a == REG_STAT && r_flag) r_armed = 1;
    if (a == REG_DATA) begin
      if (r_armed) r_flag = 0;
      r_armed = 0;
      if (is_wr && r_en && !r_active) begin
        r_active = 1;
        r_j = -1;
      end
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
    model_access(a, d, 1'b1);
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_rd = 1'b0;
    model_access(a, 8'h00, 1'b0);
  endtask

  function automatic int bit_idx(input int i);
    return r_lsb ? i : 7 - i;
  endfunction

  task automatic slave_load(input logic [7:0] b);
    s_tx = b; s_rx = '0; s_cnt = 0; s_prev = sclk;
    miso = b[bit_idx(0)];
  endtask

  task automatic wait_idle();
    while (r_active) @(negedge clk);
    @(negedge clk);
  endtask

  // cycle-by-cycle reference comparison
  always @(negedge clk) begin
    if (mon_on) begin
      int h, e;
      if (r_abort == 1) r_abort = 2;
      else if (r_abort == 2) begin r_active = 0; r_abort = 0; end
      h = 1 << r_rate;
      if (r_active) begin
        r_j++;
        if (r_j == 17 * h) begin r_active = 0; r_flag = 1; r_armed = 0; end
      end
      e = r_active ? ((r_j / h > 16) ? 16 : r_j / h) : 0;
      check("R2", "sclk", 32'(sclk), 32'(r_cpol ^ e[0]));
      check("R6", "ss_n", 32'(ss_n), 32'(r_auto ? !r_active : !r_force));
      check("R8", "irq", 32'(irq), 32'(r_flag && r_ie));
    end
  end

  // behavioural slave
  always @(negedge clk) begin
    if (s_cnt < 16 && sclk !== s_prev) begin
      int k;
      s_prev = sclk;
      s_cnt++;
      k = s_cnt;
      if ((k % 2 == 1) != r_cpha) s_rx[bit_idx((k - 1) / 2)] = mosi;
      if (r_cpha && (k % 2 == 1)) miso = s_tx[bit_idx((k - 1) / 2)];
      if (!r_cpha && (k % 2 == 0) && k < 16) miso = s_tx[bit_idx(k / 2)];
    end
  end

  task automatic xfer(input logic [7:0] m, input logic [7:0] s, input string req);
    logic [7:0] d;
    slave_load(s);
    host_write(REG_DATA, m);
    wait_idle();
    host_read(REG_STAT, d);
    check("R7", "status flag/busy", 32'(d), 32'h80);
    host_read(REG_DATA, d);
    check(req, "received byte", 32'(d), 32'(s));
    check(req, "byte seen by slave", 32'(s_rx), 32'(m));
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check("R1", "reset sclk", 32'(sclk), 32'h0);
    check("R1", "reset ss_n", 32'(ss_n), 32'h1);
    check("R1", "reset irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    mon_on = 1;
    host_read(REG_STAT, d); check("R1", "reset status", 32'(d), 32'h0);
    host_read(REG_CTRL, d); check("R1", "reset control", 32'(d), 32'h0);
    host_read(REG_DATA, d); check("R1", "reset data", 32'(d), 32'h0);

    // basic exchange: enable, auto select, interrupts
    host_write(REG_RATE, 8'h00);
    host_write(REG_CTRL, 8'h31);
    xfer(8'hA5, 8'h3C, "R4");

    // busy bit visible mid-exchange, then flag clear sequence
    host_write(REG_RATE, 8'h02);
    slave_load(8'h0F);
    host_write(REG_DATA, 8'h5A);
    repeat (6) @(negedge clk);
    host_read(REG_STAT, d);
    check("R2", "busy during exchange", 32'(d), 32'h01);
    wait_idle();
    check("R8", "irq after completion", 32'(irq), 32'h1);
    host_read(REG_DATA, d);
    check("R9", "flag kept without status read", 32'(irq), 32'h1);
    host_read(REG_STAT, d);
    host_read(REG_DATA, d);
    check("R9", "flag cleared by sequence", 32'(irq), 32'h0);
    check("R7", "received byte", 32'(d), 32'h0F);

    // every polarity, phase and order combination
    for (int m = 0; m < 8; m++) begin
      host_write(REG_RATE, 8'(m % 3));
      host_write(REG_CTRL, 8'h31 | 8'(m << 1));
      xfer(8'(8'h13 + m * 29), 8'(8'hC3 ^ (m * 17)), (m >= 4) ? "R5" : "R4");
    end

    // slowest and a middle rate
    host_write(REG_CTRL, 8'h31);
    host_write(REG_RATE, 8'h07);
    xfer(8'h6E, 8'h91, "R2");
    host_write(REG_RATE, 8'h03);
    xfer(8'hC8, 8'h27, "R2");

    // write during exchange is dropped
    host_write(REG_RATE, 8'h01);
    slave_load(8'h96);
    host_write(REG_DATA, 8'h81);
    repeat (5) @(negedge clk);
    host_write(REG_DATA, 8'h7E);
    wait_idle();
    host_read(REG_STAT, d);
    host_read(REG_DATA, d);
    check("R10", "slave saw first byte", 32'(s_rx), 32'h81);
    check("R10", "received byte", 32'(d), 32'h96);

    // disabled write and abort
    host_write(REG_CTRL, 8'h30);
    host_write(REG_DATA, 8'h55);
    repeat (20) @(negedge clk);
    host_read(REG_STAT, d);
    check("R11", "no start while disabled", 32'(d), 32'h00);
    host_write(REG_CTRL, 8'h31);
    host_write(REG_RATE, 8'h02);
    host_write(REG_DATA, 8'h3A);
    repeat (10) @(negedge clk);
    host_write(REG_CTRL, 8'h30);
    repeat (10) @(negedge clk);
    host_read(REG_STAT, d);
    check("R11", "abort leaves idle, no flag", 32'(d), 32'h00);
    check("R11", "sclk at rest", 32'(sclk), 32'h0);

    // manual select held across bytes
    host_write(REG_RATE, 8'h00);
    host_write(REG_CTRL, 8'h63);
    check("R6", "manual select low", 32'(ss_n), 32'h0);
    xfer(8'h12, 8'hED, "R6");
    xfer(8'h34, 8'hCB, "R6");
    host_write(REG_CTRL, 8'h23);
    @(negedge clk);
    check("R6", "manual select released", 32'(ss_n), 32'h1);
    check("R3", "sclk rests high", 32'(sclk), 32'h1);

    // interrupt gating
    host_write(REG_CTRL, 8'h11);
    slave_load(8'h44);
    host_write(REG_DATA, 8'hBB);
    wait_idle();
    check("R8", "irq masked", 32'(irq), 32'h0);
    host_read(REG_STAT, d);
    check("R8", "flag set while masked", 32'(d), 32'h80);
    host_write(REG_CTRL, 8'h31);
    @(negedge clk);
    check("R8", "irq after unmask", 32'(irq), 32'h1);
    host_read(REG_STAT, d);
    host_read(REG_DATA, d);
    check("R9", "flag cleared", 32'(irq), 32'h0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule